// File: doc/BRIEF.md
# Timed Strobe Bridge for a Two-Location 16-bit Peripheral

This block sits on a processor's memory-mapped slave port and gives software access to an external 16-bit peripheral. The peripheral has chip-select, read and write strobes, a single address pin and a shared data bus, and it has no clock. The bridge produces its bus cycle by counting system clocks. It also holds a small set of local registers. These registers drive a DMA enable pin and an interrupt-acknowledge pin, and they let software mask the peripheral interrupt and read its raw state.

The slave address is a 2-bit word index. Bit 0 goes straight to the peripheral address pin. Bit 1 chooses between the peripheral (0) and the local registers (1). A peripheral access stalls the processor with waitrequest while the bridge runs one setup, strobe and hold sequence. A local access completes in the same cycle it is presented.

Top module: `pbus_bridge`

## Requirements
- R1: While `dev_cs` is high, `dev_a0` equals bit 0 of the slave address of the access in progress, and it holds that value for the whole device cycle.
- R2: When `s_addr[1]` is 1, the access goes to a local register. It completes with `s_wait` low in the cycle it is presented, and it never asserts `dev_cs`, `dev_rd` or `dev_wr`.
- R3: Each peripheral access with `s_addr[1]`=0 gives exactly one strobe pulse. A slave read gives one `dev_rd` pulse and never `dev_wr`. A slave write gives one `dev_wr` pulse and never `dev_rd`. A strobe is never active without `dev_cs`.
- R4: Take the first cycle in which a peripheral request is presented as cycle 0. `dev_cs` is high from cycle 1 through cycle SETUP_CYC+STROBE_CYC+HOLD_CYC. The strobe is high for STROBE_CYC cycles, starting at cycle SETUP_CYC+1. `s_wait` is high from cycle 0 through cycle SETUP_CYC+STROBE_CYC+HOLD_CYC, then low in the next cycle.
- R5: For a peripheral read, the bridge samples `dev_din` at the clock edge that ends the last strobe cycle. It presents that value on `s_rdata` in the cycle where `s_wait` is low.
- R6: During a peripheral write, `dev_oe` is high and `dev_dout` equals the write data for every cycle in which `dev_cs` is high. At all other times `dev_oe` is low.
- R7: A write to word 2 stores bit 0 as DMA enable, which drives `dma_en`, and bit 1 as interrupt enable. A read of word 2 returns the two bits in the same positions, with zeros above them.
- R8: A read of word 3 returns the synchronized, unmasked peripheral interrupt in bit 0. A write to word 3 with bit 0 set drives `irq_ack` high for exactly the one cycle after the write. A write with bit 0 clear leaves `irq_ack` low.
- R9: `s_irq` equals `dev_irq` delayed through two clock edges, ANDed with the interrupt-enable bit.
- R10: In reset and right after it, all device strobes, `dev_cs`, `dev_oe`, `dma_en`, `irq_ack` and `s_irq` are low, and word 2 reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| s_cs | input | 1 | Slave chip-select |
| s_rd | input | 1 | Slave read request |
| s_wr | input | 1 | Slave write request |
| s_addr | input | 2 | Word address: bit 0 selects the peripheral location, bit 1 selects local registers |
| s_wdata | input | 16 | Slave write data |
| s_rdata | output | 16 | Slave read data |
| s_wait | output | 1 | Wait request; stalls the processor during a peripheral cycle |
| s_irq | output | 1 | Masked interrupt to the processor |
| dev_cs | output | 1 | Peripheral chip-select |
| dev_rd | output | 1 | Peripheral read strobe |
| dev_wr | output | 1 | Peripheral write strobe |
| dev_a0 | output | 1 | Peripheral address pin |
| dev_din | input | 16 | Data from the peripheral bus |
| dev_dout | output | 16 | Data to the peripheral bus |
| dev_oe | output | 1 | Output enable for the peripheral data bus |
| dev_irq | input | 1 | Peripheral interrupt (asynchronous) |
| dma_en | output | 1 | DMA enable pin |
| irq_ack | output | 1 | One-cycle interrupt acknowledge pulse |

## Verification
On every cycle, the assertions check the following:
- Strobes appear only under chip-select, and never both at once.
- The address pin stays still during a device cycle.
- Output enable never overlaps a read strobe.
- A strobe always follows at least one setup cycle.
- Local accesses never wait.
- An acknowledge pulse always comes from a qualifying write.

The exact cycle counts of setup, strobe and hold, and the point at which read data is sampled, can only be shown by the bench's scenarios. The same holds for the two-edge interrupt latency, the masking and the register readback. The bench shows these by comparing its own per-cycle model with the outputs, and by changing the device data around the last strobe cycle.

// File: rtl/pbus_bridge.sv
module pbus_bridge #(
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 1,
  parameter int STROBE_CYC = 2,
  parameter int HOLD_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_cs,
  input  logic          s_rd,
  input  logic          s_wr,
  input  logic [1:0]    s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  output logic          s_wait,
  output logic          s_irq,
  output logic          dev_cs,
  output logic          dev_rd,
  output logic          dev_wr,
  output logic          dev_a0,
  input  logic [DW-1:0] dev_din,
  output logic [DW-1:0] dev_dout,
  output logic          dev_oe,
  input  logic          dev_irq,
  output logic          dma_en,
  output logic          irq_ack
);
  localparam int CW = $clog2(SETUP_CYC + STROBE_CYC + HOLD_CYC + 1);

  typedef enum logic [2:0] {IDLE, SETUP, STRB, HOLD, DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          is_wr, a0_q, dma_q, ien_q, ack_q;
  logic [DW-1:0] wbuf, rcap;
  logic [1:0]    isync;

  wire dev_req = s_cs & (s_rd | s_wr) & ~s_addr[1];
  wire loc_wr  = s_cs & s_wr & s_addr[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      a0_q  <= 1'b0;
      wbuf  <= '0;
      rcap  <= '0;
    end else begin
      case (st)
        IDLE: if (dev_req) begin
          st    <= SETUP;
          cnt   <= '0;
          is_wr <= s_wr;
          a0_q  <= s_addr[0];
          wbuf  <= s_wdata;
        end
        SETUP: if (cnt == CW'(SETUP_CYC - 1)) begin
          st  <= STRB;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        STRB: if (cnt == CW'(STROBE_CYC - 1)) begin
          st  <= HOLD;
          cnt <= '0;
          if (!is_wr) rcap <= dev_din;
        end else cnt <= cnt + 1'b1;
        HOLD: if (cnt == CW'(HOLD_CYC - 1)) begin
          st  <= DONE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_q <= 1'b0;
      ien_q <= 1'b0;
      ack_q <= 1'b0;
      isync <= 2'b00;
    end else begin
      isync <= {isync[0], dev_irq};
      ack_q <= loc_wr & s_addr[0] & s_wdata[0];
      if (loc_wr && !s_addr[0]) begin
        dma_q <= s_wdata[0];
        ien_q <= s_wdata[1];
      end
    end
  end

  assign dev_cs   = (st == SETUP) || (st == STRB) || (st == HOLD);
  assign dev_rd   = (st == STRB) && !is_wr;
  assign dev_wr   = (st == STRB) && is_wr;
  assign dev_oe   = dev_cs && is_wr;
  assign dev_a0   = a0_q;
  assign dev_dout = wbuf;
  assign s_wait   = dev_req && (st != DONE);
  assign s_irq    = isync[1] & ien_q;
  assign dma_en   = dma_q;
  assign irq_ack  = ack_q;
  assign s_rdata  = !s_addr[1] ? rcap :
                    s_addr[0]  ? {{(DW-1){1'b0}}, isync[1]} :
                                 {{(DW-2){1'b0}}, ien_q, dma_q};

  a_r3_strobe_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rd || dev_wr) |-> dev_cs);
  a_r3_single_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_rd && dev_wr));
  a_r6_oe_not_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dev_oe |-> !dev_rd);
  a_r1_a0_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_cs && $past(dev_cs)) |-> $stable(dev_a0));
  a_r4_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_rd || dev_wr) |-> $past(dev_cs));
  a_r2_local_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (s_cs && s_addr[1]) |-> !s_wait);
  a_r8_ack_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(s_cs && s_wr && s_addr == 2'd3 && s_wdata[0]));
endmodule

// File: tb/pbus_bridge_tb_top.sv
`timescale 1ns/1ps
module pbus_bridge_tb_top;
  localparam int S = 2, T = 3, H = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        s_cs = 0, s_rd = 0, s_wr = 0;
  logic [1:0]  s_addr = 0;
  logic [15:0] s_wdata = 0, dev_din = 0;
  logic        dev_irq = 0;
  logic [15:0] s_rdata, dev_dout;
  logic        s_wait, s_irq, dev_cs, dev_rd, dev_wr, dev_a0, dev_oe, dma_en, irq_ack;

  int n_chk = 0, n_bad = 0;
  bit in_dev = 0;

  pbus_bridge #(.DW(16), .SETUP_CYC(S), .STROBE_CYC(T), .HOLD_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr),
    .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_wait(s_wait),
    .s_irq(s_irq), .dev_cs(dev_cs), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_a0(dev_a0), .dev_din(dev_din), .dev_dout(dev_dout), .dev_oe(dev_oe),
    .dev_irq(dev_irq), .dma_en(dma_en), .irq_ack(irq_ack));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!in_dev) begin
    chk("R2 no device cs outside device access", dev_cs, 0);
    chk("R3 no strobe outside device access", dev_rd | dev_wr, 0);
    chk("R6 oe low outside write", dev_oe, 0);
  end

  task automatic dev_access(input bit w, input bit a0, input logic [15:0] wd, input logic [15:0] rv);
    int last;
    bit ecs, estb;
    last = S + T + H + 1;
    @(posedge clk); #1;
    in_dev = 1;
    s_cs = 1; s_rd = !w; s_wr = w; s_addr = {1'b0, a0}; s_wdata = wd; dev_din = 16'hBAD0;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      ecs  = (k >= 1) && (k <= S + T + H);
      estb = (k >= S + 1) && (k <= S + T);
      chk("R4 waitrequest", s_wait, k < last);
      chk("R4 dev_cs window", dev_cs, ecs);
      chk("R3 read strobe", dev_rd, estb && !w);
      chk("R3 write strobe", dev_wr, estb && w);
      chk("R6 output enable", dev_oe, ecs && w);
      if (ecs) chk("R1 address pin", dev_a0, a0);
      if (ecs && w) chk("R6 write data", dev_dout, wd);
      if (k == last && !w) chk("R5 read data", s_rdata, rv);
      if (k == S + T) dev_din = rv;
      if (k == S + T + 1) dev_din = 16'hBAD1;
    end
    @(posedge clk); #1;
    s_cs = 0; s_rd = 0; s_wr = 0;
    in_dev = 0;
  endtask

  task automatic loc_write(input bit lo, input logic [15:0] d);
    @(posedge clk); #1;
    s_cs = 1; s_wr = 1; s_addr = {1'b1, lo}; s_wdata = d;
    @(negedge clk);
    chk("R2 local write no wait", s_wait, 0);
    @(posedge clk); #1;
    s_cs = 0; s_wr = 0;
  endtask

  task automatic loc_read(input bit lo, input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    s_cs = 1; s_rd = 1; s_addr = {1'b1, lo};
    @(negedge clk);
    chk("R2 local read no wait", s_wait, 0);
    chk(tag, s_rdata, e);
    @(posedge clk); #1;
    s_cs = 0; s_rd = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset wait", s_wait, 0);
    chk("R10 reset dma_en", dma_en, 0);
    chk("R10 reset irq_ack", irq_ack, 0);
    chk("R10 reset irq", s_irq, 0);
    @(posedge clk); #1 rst_n = 1;
    loc_read(0, 16'h0000, "R10 control clear after reset");

    dev_access(0, 0, 16'h0000, 16'h1234);
    dev_access(0, 1, 16'h0000, 16'hA55A);
    dev_access(1, 0, 16'hC0DE, 16'h0000);
    dev_access(1, 1, 16'h0F0F, 16'h0000);
    dev_access(0, 1, 16'h0000, 16'hFFFF);

    loc_write(0, 16'h0001);
    @(negedge clk);
    chk("R7 dma_en pin set", dma_en, 1);
    loc_read(0, 16'h0001, "R7 control readback dma");
    loc_write(0, 16'hFFFE);
    @(negedge clk);
    chk("R7 dma_en pin clear", dma_en, 0);
    loc_read(0, 16'h0002, "R7 control readback irq enable");

    @(posedge clk); #1 dev_irq = 1;
    @(negedge clk); chk("R9 irq latency 0 edges", s_irq, 0);
    @(negedge clk); chk("R9 irq latency 1 edge", s_irq, 0);
    @(negedge clk); chk("R9 irq after 2 edges", s_irq, 1);
    loc_read(1, 16'h0001, "R8 raw interrupt status");
    loc_write(0, 16'h0001);
    @(negedge clk);
    chk("R9 irq masked", s_irq, 0);
    loc_read(1, 16'h0001, "R8 status unmasked when disabled");
    @(posedge clk); #1 dev_irq = 0;
    repeat (3) @(negedge clk);
    loc_read(1, 16'h0000, "R8 status follows interrupt low");

    loc_write(1, 16'h0001);
    @(negedge clk); chk("R8 ack pulse high", irq_ack, 1);
    @(negedge clk); chk("R8 ack pulse one cycle", irq_ack, 0);
    loc_write(1, 16'hFFFE);
    @(negedge clk); chk("R8 no ack on bit0 clear", irq_ack, 0);
    chk("R7 dma unchanged by word 3 write", dma_en, 1);

    dev_access(0, 0, 16'h0000, 16'h5AA5);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule